// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block keeps one readiness flag for every physical register seen by an instruction queue, together with the set of queue slots waiting on each register. Integer and floating-point registers share one flat index space: integer index `i` maps to flat entry `i`, and floating-point index `j` maps to flat entry `NUM_INT + j`. A flag of 1 means the register's value has been produced. A flag of 0 means a producer has been recorded and the value has not yet arrived.

There are three command ports. An allocation marks a destination register as pending. A query, made when a consumer enters the queue, reports whether its source register is ready. If the register is not ready, the consumer's slot number is recorded as a dependent of that register. A completion marks the register ready and releases its dependents. One cycle later the block reports the released slot mask and how many slots it holds.

Every port is a plain command strobe with a matching valid bit. Each command is accepted in the cycle its valid is high, so there is no back-pressure and no ready handshake. The query answer is combinational in the same cycle. The wake report is registered and appears in the cycle after the completion.

Top module: `wk_scoreboard`

## Requirements
- R1: After reset every register reads ready (`qry_ready`=1 for any valid query) and `wake_valid` is 0.
- R2: Integer index i selects flat entry i and floating-point index j selects flat entry NUM_INT+j. Integer index k and floating-point index k are distinct registers.
- R3: An allocation (`alloc_valid`=1) makes queries to that register return 0 from the next cycle on, until a completion arrives.
- R4: A query that returns 0 adds bit `qry_slot` to that register's dependent mask. A query that returns 1 adds nothing.
- R5: A completion (`cmp_valid`=1) produces `wake_valid`=1 in the next cycle. In that cycle `wake_mask` equals the register's dependent mask and `wake_count` equals the number of set bits in it. Afterwards the register reads ready and its mask is empty, so a second completion reports mask 0 and count 0.
- R6: A query in the same cycle as a completion of the same register returns 1 and is not recorded.
- R7: An allocation and a completion of the same register in the same cycle leave the register pending. The completion still reports and clears the old dependents.
- R8: `wake_valid` is 0 in every cycle that follows a cycle without a completion.
- R9: All SLOTS slots can wait on one register. The completion then reports `wake_count`=SLOTS.
- R10: A query in the same cycle as an allocation of the same register sees the state from before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Record a producer for a register |
| alloc_fp | input | 1 | Register class for the allocation: 0 integer, 1 floating point |
| alloc_idx | input | IDX_W | Index within the class |
| qry_valid | input | 1 | Consumer source query |
| qry_fp | input | 1 | Register class for the query |
| qry_idx | input | IDX_W | Index within the class |
| qry_slot | input | SLOT_W | Queue slot of the querying consumer |
| qry_ready | output | 1 | Source ready now (combinational) |
| cmp_valid | input | 1 | Completion broadcast for a register |
| cmp_fp | input | 1 | Register class for the completion |
| cmp_idx | input | IDX_W | Index within the class |
| wake_valid | output | 1 | Wake report valid (one cycle after a completion) |
| wake_mask | output | SLOTS | Slots released by the completion |
| wake_count | output | CNT_W | Number of released slots |

## Verification
The bench checks that integer and floating-point registers with the same index stay apart. A design that dropped the offset would show the floating-point register as pending after an integer allocation. It collides a query with a completion of the same register. A design without the bypass would record the slot and release it on a later wake, giving a wrong mask. It also collides an allocation with a completion. If the completion won, the register would read ready, and if the allocation won outright, the old dependents would be lost. It fills all sixteen slots on one register, which catches a count that is too narrow and wraps to zero. It also issues a second completion, which catches a mask that was never cleared.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FP  = 1'b1
  } reg_cls_e;

  localparam int DEF_NUM_INT = 96;
  localparam int DEF_NUM_FP  = 96;
  localparam int DEF_SLOTS   = 16;
endpackage

// File: rtl/wk_regmap.sv
module wk_regmap #(
  parameter int NUM_INT = 96,
  parameter int IDX_W   = 7,
  parameter int FLAT_W  = 8
) (
  input  wk_pkg::reg_cls_e cls,
  input  logic [IDX_W-1:0] idx,
  output logic [FLAT_W-1:0] flat
);
  // floating-point entries sit directly after the integer entries
  always_comb begin
    if (cls == wk_pkg::CLS_FP) flat = FLAT_W'(NUM_INT) + FLAT_W'(idx);
    else                       flat = FLAT_W'(idx);
  end
endmodule

// File: rtl/wk_row.sv
module wk_row #(
  parameter int SLOTS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_hit,
  input  logic             cmp_hit,
  input  logic             add_hit,
  input  logic [SLOTS-1:0] add_oh,
  output logic             ready_q,
  output logic [SLOTS-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      mask_q  <= '0;
    end else begin
      // a new producer outranks a completing older one
      if (alloc_hit)    ready_q <= 1'b0;
      else if (cmp_hit) ready_q <= 1'b1;
      if (cmp_hit)      mask_q  <= '0;
      else if (add_hit) mask_q  <= mask_q | add_oh;
    end
  end

  p_alloc_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_hit |=> !ready_q);
  p_complete_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !alloc_hit) |=> (ready_q && mask_q == '0));
  p_alloc_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && alloc_hit) |=> (!ready_q && mask_q == '0));
  p_record_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (add_hit && !cmp_hit) |=> ((mask_q & $past(add_oh)) != '0));
  p_deps_only_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> !ready_q);
endmodule

// File: rtl/wk_wake_out.sv
module wk_wake_out #(
  parameter int SLOTS = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic [SLOTS-1:0] sel_mask,
  output logic             wake_valid,
  output logic [SLOTS-1:0] wake_mask,
  output logic [CNT_W-1:0] wake_count
);
  logic [CNT_W-1:0] pop;

  always_comb begin
    pop = '0;
    for (int s = 0; s < SLOTS; s++) pop = pop + CNT_W'(sel_mask[s]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
      wake_count <= '0;
    end else begin
      wake_valid <= cmp_valid;
      wake_mask  <= cmp_valid ? sel_mask : '0;
      wake_count <= cmp_valid ? pop : '0;
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !wake_valid);
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (32'(wake_count) <= SLOTS));
  p_empty_mask_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_valid && wake_mask == '0) |-> (wake_count == '0));
endmodule

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
  parameter int NUM_INT = wk_pkg::DEF_NUM_INT,
  parameter int NUM_FP  = wk_pkg::DEF_NUM_FP,
  parameter int SLOTS   = wk_pkg::DEF_SLOTS,
  localparam int NUM_REGS = NUM_INT + NUM_FP,
  localparam int IDX_W    = $clog2((NUM_INT > NUM_FP) ? NUM_INT : NUM_FP),
  localparam int FLAT_W   = $clog2(NUM_REGS),
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_fp,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              qry_valid,
  input  logic              qry_fp,
  input  logic [IDX_W-1:0]  qry_idx,
  input  logic [SLOT_W-1:0] qry_slot,
  output logic              qry_ready,
  input  logic              cmp_valid,
  input  logic              cmp_fp,
  input  logic [IDX_W-1:0]  cmp_idx,
  output logic              wake_valid,
  output logic [SLOTS-1:0]  wake_mask,
  output logic [CNT_W-1:0]  wake_count
);
  logic [FLAT_W-1:0] a_flat, q_flat, c_flat;
  logic [NUM_REGS-1:0] ready_vec;
  logic [SLOTS-1:0]    mask_arr [NUM_REGS];
  logic [SLOTS-1:0]    add_oh, c_mask;
  logic                q_bit, q_add, cq_same;

  wk_regmap #(.NUM_INT(NUM_INT), .IDX_W(IDX_W), .FLAT_W(FLAT_W)) u_map_a (
    .cls(wk_pkg::reg_cls_e'(alloc_fp)), .idx(alloc_idx), .flat(a_flat));
  wk_regmap #(.NUM_INT(NUM_INT), .IDX_W(IDX_W), .FLAT_W(FLAT_W)) u_map_q (
    .cls(wk_pkg::reg_cls_e'(qry_fp)), .idx(qry_idx), .flat(q_flat));
  wk_regmap #(.NUM_INT(NUM_INT), .IDX_W(IDX_W), .FLAT_W(FLAT_W)) u_map_c (
    .cls(wk_pkg::reg_cls_e'(cmp_fp)), .idx(cmp_idx), .flat(c_flat));

  assign add_oh  = SLOTS'(1) << qry_slot;
  assign cq_same = cmp_valid && (c_flat == q_flat);

  always_comb begin
    q_bit  = (32'(q_flat) < NUM_REGS) ? ready_vec[q_flat] : 1'b1;
    c_mask = (32'(c_flat) < NUM_REGS) ? mask_arr[c_flat] : '0;
  end

  // completion of the same register in this cycle forwards into the query
  assign qry_ready = q_bit | cq_same;
  assign q_add     = qry_valid && !qry_ready;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    wk_row #(.SLOTS(SLOTS)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .alloc_hit(alloc_valid && (32'(a_flat) == r)),
      .cmp_hit  (cmp_valid && (32'(c_flat) == r)),
      .add_hit  (q_add && (32'(q_flat) == r)),
      .add_oh   (add_oh),
      .ready_q  (ready_vec[r]),
      .mask_q   (mask_arr[r])
    );
  end

  wk_wake_out #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .sel_mask  (c_mask),
    .wake_valid(wake_valid),
    .wake_mask (wake_mask),
    .wake_count(wake_count)
  );

  p_index_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid || alloc_valid || cmp_valid) |->
      (32'(q_flat) < NUM_REGS && 32'(a_flat) < NUM_REGS && 32'(c_flat) < NUM_REGS));
  p_fp_above_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_fp) |-> (32'(q_flat) >= NUM_INT));
  p_bypass_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && cq_same) |=> (wake_mask & $past(add_oh)) == '0);
endmodule

// File: tb/wk_scoreboard_test.sv
module wk_scoreboard_test;
  localparam int NI = 96, NF = 96, NS = 16, NR = NI + NF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_fp = 0, qry_valid = 0, qry_fp = 0, cmp_valid = 0, cmp_fp = 0;
  logic [6:0] alloc_idx = '0, qry_idx = '0, cmp_idx = '0;
  logic [3:0] qry_slot = '0;
  logic qry_ready, wake_valid;
  logic [15:0] wake_mask;
  logic [4:0] wake_count;

  always #2.5 clk = ~clk;

  wk_scoreboard uut (.*);

  typedef struct { logic [15:0] m; int c; string tag; } exp_t;
  exp_t expq[$];
  int n_checks = 0, n_fail = 0;
  bit running = 0, done = 0;
  bit          m_rdy [NR];
  logic [15:0] m_msk [NR];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int flat(input bit fp, input int i);
    return fp ? NI + i : i;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // one command cycle: drive, check the combinational answer, push the wake item
  task automatic step(input bit av, input bit afp, input int ai,
                      input bit qv, input bit qfp, input int qi, input int qs,
                      input bit cv, input bit cfp, input int ci, input string tag);
    int af, qf, cf;
    bit erdy;
    exp_t e;
    @(negedge clk);
    #1;
    alloc_valid = av; alloc_fp = afp; alloc_idx = 7'(ai);
    qry_valid = qv; qry_fp = qfp; qry_idx = 7'(qi); qry_slot = 4'(qs);
    cmp_valid = cv; cmp_fp = cfp; cmp_idx = 7'(ci);
    af = flat(afp, ai); qf = flat(qfp, qi); cf = flat(cfp, ci);
    erdy = m_rdy[qf] | (cv && cf == qf);
    #0.5;
    if (qv) chk(qry_ready == erdy, {tag, " query"}, int'(qry_ready), int'(erdy));
    if (cv) begin
      e.m = m_msk[cf];
      e.c = $countones(m_msk[cf]);
      e.tag = tag;
      expq.push_back(e);
      m_msk[cf] = '0;
      m_rdy[cf] = 1'b1;
    end
    if (av) m_rdy[af] = 1'b0;
    if (qv && !erdy) m_msk[qf] = m_msk[qf] | (16'(1) << qs);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  // monitor: compares wake reports against the expected queue
  always @(negedge clk) begin
    if (running) begin
      if (expq.size() != 0) begin
        exp_t e;
        e = expq.pop_front();
        chk(wake_valid == 1'b1, {e.tag, " wake_valid"}, int'(wake_valid), 1);
        chk(wake_mask == e.m, {e.tag, " wake_mask"}, int'(wake_mask), int'(e.m));
        chk(int'(wake_count) == e.c, {e.tag, " wake_count"}, int'(wake_count), e.c);
      end else if (wake_valid) begin
        chk(1'b0, "R8 unexpected wake", 1, 0);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_rdy[r] = 1'b1;
      m_msk[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    #1;
    chk(wake_valid == 1'b0, "R1 wake_valid after reset", int'(wake_valid), 0);
    // R1: every class edge reads ready
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 95, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 1, 95, 0, 0, 0, 0, "R1");
    // R3 R2: integer 5 pending, floating 5 untouched
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 0, 5, 3, 0, 0, 0, "R3");
    step(0, 0, 0, 1, 1, 5, 9, 0, 0, 0, "R2");
    step(1, 1, 95, 1, 0, 95, 2, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 0, 95, 2, 0, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 95, 4, 0, 0, 0, "R2");
    // R4 R5: second dependent, completion releases slots 3 and 7
    step(0, 0, 0, 1, 0, 5, 7, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 5, "R4 R5");
    step(0, 0, 0, 1, 0, 5, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 5, "R5");
    idle();
    // R6: bypass on a same-cycle completion
    step(1, 0, 10, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 10, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 10, 2, 1, 0, 10, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 10, "R6");
    // R7: allocation and completion collide
    step(1, 0, 20, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 20, 4, 0, 0, 0, "R7");
    step(1, 0, 20, 0, 0, 0, 0, 1, 0, 20, "R7");
    step(0, 0, 0, 1, 0, 20, 6, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 20, "R7");
    // R9: all slots wait on floating 95 (still pending)
    for (int s = 0; s < NS; s++) step(0, 0, 0, 1, 1, 95, s, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 95, "R9");
    // R10: query sees the state from before a same-cycle allocation
    step(1, 0, 30, 1, 0, 30, 5, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 0, 30, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 30, "R10");
    // R8: quiet cycles
    idle();
    idle();
    idle();
    #1;
    chk(wake_valid == 1'b0, "R8 idle", int'(wake_valid), 0);
    chk(expq.size() == 0, "R5 pending reports", expq.size(), 0);
    finish_run();
  end
endmodule